// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer and Status Encoder

This block sits inside one UART channel. It collects seven interrupt sources: line status error, receive data ready, receive data timeout, transmit holding register empty, modem status change, Xoff/special character detection and CTS/RTS change of state. At any time it presents only the most urgent pending source, as an 8-bit status byte on the register read port, and drives a single active-high interrupt line.

Sources that are raised by a one-cycle event are held in sticky bits. A read of the status register, flagged by a one-cycle strobe, clears the source that is being reported. Lower-priority sources then show up on the following reads. The two receive-data conditions are levels owned by the FIFO logic, so a read does not clear them. The Xoff indication is only cleared when an Xon is detected. The two extended sources can only be reported while the extended-features enable is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source pending, bits 5:0 of `isr` read 0x01 and `irq` is low. Bit 0 is active low: it is 0 only while a source is being reported.
- R2: Bits 7:6 of `isr` both equal `fifo_en`.
- R3: Bits 5:0 report the highest pending source. The sources, from highest to lowest priority, and their codes are: line error 0x06, receive ready 0x04, receive timeout 0x0C, transmit holding empty 0x02, modem change 0x00, Xoff/special 0x10, CTS/RTS change 0x20.
- R4: When receive ready and receive timeout are both pending, receive ready is reported. These two are levels, and a read leaves them unchanged.
- R5: A read (`rd_isr` high for one cycle) clears only the event source being reported. This applies to line error, transmit holding empty, modem change and CTS/RTS change. The next lower pending source is shown in the following cycle. A read with nothing pending has no effect.
- R6: If an event arrives in the same cycle as a read that clears that source, the event is kept.
- R7: With `ext_en` low, codes 0x10 and 0x20 are never reported. Those events are still latched and appear once `ext_en` is set.
- R8: The Xoff indication survives reads and is cleared only by `xon_det`. If `xoff_det` and `xon_det` are high in the same cycle, the indication is set.
- R9: The enable mapping is: `src_en[0]` line error, `src_en[1]` both receive conditions, `src_en[2]` transmit holding empty, `src_en[3]` modem change, `src_en[4]` Xoff/special, `src_en[5]` CTS/RTS change. A disabled source is not reported, but its latch is kept.
- R10: `irq` is high exactly when `isr[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 6 | Per-source interrupt enables |
| ext_en | input | 1 | Extended-features enable (levels 5 and 6) |
| fifo_en | input | 1 | FIFOs in use |
| line_err_evt | input | 1 | Line status error event |
| rx_ready | input | 1 | Receive data ready level |
| rx_timeout | input | 1 | Receive timeout level |
| thr_empty_evt | input | 1 | Transmit holding empty event |
| modem_evt | input | 1 | Modem status change event |
| xoff_det | input | 1 | Xoff or special character detected |
| xon_det | input | 1 | Xon character detected |
| flow_evt | input | 1 | CTS/RTS change of state event |
| rd_isr | input | 1 | Status register read strobe |
| isr | output | 8 | Encoded interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The prioritizer is driven with pairs of adjacent-priority sources at the same time, so each code in the table is shown to outrank the next one. It is also driven with single sources, to show each code on its own. Enable patterns with one bit dropped show that the mask goes to the right source and does not erase it. Toggling the FIFO and extended enables separates the status prefix from the source code. Read sequences over several latched events show that clearing is done in priority order. Reads that coincide with a new event, reads of level sources, and Xoff/Xon ordering show which state a read is allowed to touch.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 7;
  localparam int NSTICK = 5;
  localparam int NEN    = 6;
  localparam int ISR_W  = 8;
  localparam int CODE_W = 6;

  typedef enum logic [2:0] {
    SRC_LINE  = 3'd0,
    SRC_RXRDY = 3'd1,
    SRC_RXTO  = 3'd2,
    SRC_THRE  = 3'd3,
    SRC_MODEM = 3'd4,
    SRC_XOFF  = 3'd5,
    SRC_FLOW  = 3'd6,
    SRC_NONE  = 3'd7
  } src_e;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'h01;

  function automatic logic [CODE_W-1:0] code_of(input src_e s);
    case (s)
      SRC_LINE:  code_of = 6'h06;
      SRC_RXRDY: code_of = 6'h04;
      SRC_RXTO:  code_of = 6'h0C;
      SRC_THRE:  code_of = 6'h02;
      SRC_MODEM: code_of = 6'h00;
      SRC_XOFF:  code_of = 6'h10;
      SRC_FLOW:  code_of = 6'h20;
      default:   code_of = CODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         upd;

  // a set always wins over a clear in the same cycle
  always_comb begin
    upd   = (|set) || (|clr);
    q_nxt = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] pend,
  output src_e         sel,
  output logic         any
);

  // lowest index is most urgent
  always_comb begin
    sel = SRC_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) sel = src_e'(i);
    end
    any = |pend;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEN-1:0]   src_en,
  input  logic             ext_en,
  input  logic             fifo_en,
  input  logic             line_err_evt,
  input  logic             rx_ready,
  input  logic             rx_timeout,
  input  logic             thr_empty_evt,
  input  logic             modem_evt,
  input  logic             xoff_det,
  input  logic             xon_det,
  input  logic             flow_evt,
  input  logic             rd_isr,
  output logic [ISR_W-1:0] isr,
  output logic             irq
);

  localparam int PFX_W = ISR_W - CODE_W;

  // sticky index: 0 line, 1 thre, 2 modem, 3 xoff, 4 flow
  logic [NSTICK-1:0] st_set, st_clr, st_q;
  logic [NSRC-1:0]   raw, mask, pend;
  src_e              sel;
  logic              any;

  always_comb begin
    st_set = {flow_evt, xoff_det, modem_evt, thr_empty_evt, line_err_evt};
    st_clr[0] = rd_isr && (sel == SRC_LINE);
    st_clr[1] = rd_isr && (sel == SRC_THRE);
    st_clr[2] = rd_isr && (sel == SRC_MODEM);
    st_clr[3] = xon_det;
    st_clr[4] = rd_isr && (sel == SRC_FLOW);
  end

  irq_sticky #(.W(NSTICK)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (st_set),
    .clr   (st_clr),
    .q     (st_q)
  );

  always_comb begin
    raw[SRC_LINE]  = st_q[0];
    raw[SRC_RXRDY] = rx_ready;
    raw[SRC_RXTO]  = rx_timeout;
    raw[SRC_THRE]  = st_q[1];
    raw[SRC_MODEM] = st_q[2];
    raw[SRC_XOFF]  = st_q[3];
    raw[SRC_FLOW]  = st_q[4];

    mask[SRC_LINE]  = src_en[0];
    mask[SRC_RXRDY] = src_en[1];
    mask[SRC_RXTO]  = src_en[1];
    mask[SRC_THRE]  = src_en[2];
    mask[SRC_MODEM] = src_en[3];
    mask[SRC_XOFF]  = src_en[4] && ext_en;
    mask[SRC_FLOW]  = src_en[5] && ext_en;

    pend = raw & mask;
  end

  irq_prio_sel #(.N(NSRC)) u_sel (
    .pend (pend),
    .sel  (sel),
    .any  (any)
  );

  always_comb begin
    isr = {{PFX_W{fifo_en}}, code_of(sel)};
    irq = any;
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] src_en,
  input logic       ext_en,
  input logic       fifo_en,
  input logic       line_err_evt,
  input logic       xon_det,
  input logic       rd_isr,
  input logic [7:0] isr,
  input logic       irq
);

  // R10
  irq_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !isr[0]);

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> isr[5:0] == 6'h01);

  // R2
  fifo_pfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr[7:6] == {2{fifo_en}});

  // R7
  ext_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> isr[5:4] == 2'b00);

  // R5
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && isr[5:0] == 6'h06 && !line_err_evt) |=> isr[5:0] != 6'h06);

  // R8
  xoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && isr[5:0] == 6'h10 && !xon_det) |=> (!ext_en || !src_en[4] || irq));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_en;
  logic       ext_en, fifo_en;
  logic       line_err_evt, rx_ready, rx_timeout, thr_empty_evt;
  logic       modem_evt, xoff_det, xon_det, flow_evt, rd_isr;
  logic [7:0] isr;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_ident u0 (.*);

  // ev bits: {flow, xoff, modem, thre, line}
  typedef struct packed {
    logic [5:0] en;
    logic       ext;
    logic       fifo;
    logic [4:0] ev;
    logic       rx;
    logic       to;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{6'h3F, 1'b1, 1'b1, 5'b00011, 1'b1, 1'b0, 8'hC6},
    '{6'h3F, 1'b1, 1'b1, 5'b00000, 1'b1, 1'b1, 8'hC4},
    '{6'h3F, 1'b1, 1'b1, 5'b00010, 1'b0, 1'b1, 8'hCC},
    '{6'h3F, 1'b1, 1'b1, 5'b00110, 1'b0, 1'b0, 8'hC2},
    '{6'h3F, 1'b1, 1'b1, 5'b01100, 1'b0, 1'b0, 8'hC0},
    '{6'h3F, 1'b1, 1'b1, 5'b11000, 1'b0, 1'b0, 8'hD0},
    '{6'h3F, 1'b1, 1'b1, 5'b10000, 1'b0, 1'b0, 8'hE0},
    '{6'h3F, 1'b0, 1'b1, 5'b10000, 1'b0, 1'b0, 8'hC1},
    '{6'h3F, 1'b1, 1'b0, 5'b00010, 1'b0, 1'b0, 8'h02},
    '{6'h3E, 1'b1, 1'b1, 5'b00001, 1'b1, 1'b0, 8'hC4},
    '{6'h3F, 1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 8'hC1},
    '{6'h3D, 1'b1, 1'b1, 5'b00100, 1'b0, 1'b1, 8'hC0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: isr actual 0x%02h expected 0x%02h", req, act, exp);
    end
    // R10 checked alongside every status check
    n_chk++;
    if (irq !== !exp[0]) begin
      n_fail++;
      $display("FAIL R10: irq actual %0b expected %0b", irq, !exp[0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {line_err_evt, thr_empty_evt, modem_evt, xoff_det, xon_det, flow_evt, rd_isr} = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_ev(input logic [4:0] ev);
    {flow_evt, xoff_det, modem_evt, thr_empty_evt, line_err_evt} = ev;
    @(negedge clk);
    {flow_evt, xoff_det, modem_evt, thr_empty_evt, line_err_evt} = '0;
  endtask

  task automatic read_isr();
    rd_isr = 1'b1;
    @(negedge clk);
    rd_isr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_en = 6'h3F; ext_en = 1'b1; fifo_en = 1'b0;
    rx_ready = 1'b0; rx_timeout = 1'b0;
    {line_err_evt, thr_empty_evt, modem_evt, xoff_det, xon_det, flow_evt, rd_isr} = '0;

    // R1 reset state
    do_reset();
    check("R1", isr, 8'h01);

    // R3 R2 R7 R9 R4 table of priority patterns
    for (int i = 0; i < 12; i++) begin
      do_reset();
      src_en = TBL[i].en; ext_en = TBL[i].ext; fifo_en = TBL[i].fifo;
      rx_ready = TBL[i].rx; rx_timeout = TBL[i].to;
      pulse_ev(TBL[i].ev);
      check($sformatf("R3 vec%0d", i), isr, TBL[i].exp);
    end

    // R5 read chain clears in priority order
    do_reset();
    src_en = 6'h3F; ext_en = 1'b1; fifo_en = 1'b1; rx_ready = 1'b0; rx_timeout = 1'b0;
    pulse_ev(5'b00111);
    check("R5 line first", isr, 8'hC6);
    read_isr();
    check("R5 thre next", isr, 8'hC2);
    read_isr();
    check("R5 modem next", isr, 8'hC0);
    read_isr();
    check("R5 idle", isr, 8'hC1);
    read_isr();
    check("R5 read when idle", isr, 8'hC1);

    // R4 receive levels not cleared by read
    rx_ready = 1'b1;
    @(negedge clk);
    read_isr();
    check("R4 ready kept", isr, 8'hC4);
    rx_ready = 1'b0; rx_timeout = 1'b1;
    @(negedge clk);
    read_isr();
    check("R4 timeout kept", isr, 8'hCC);
    rx_timeout = 1'b0;
    @(negedge clk);
    check("R4 drop", isr, 8'hC1);

    // R6 event on the read cycle is kept
    pulse_ev(5'b00001);
    rd_isr = 1'b1; line_err_evt = 1'b1;
    @(negedge clk);
    rd_isr = 1'b0; line_err_evt = 1'b0;
    check("R6 kept", isr, 8'hC6);
    read_isr();
    check("R6 cleared", isr, 8'hC1);

    // R8 Xoff persists through reads, cleared by Xon
    pulse_ev(5'b01000);
    read_isr();
    read_isr();
    check("R8 persists", isr, 8'hD0);
    xon_det = 1'b1;
    @(negedge clk);
    xon_det = 1'b0;
    check("R8 xon clears", isr, 8'hC1);
    xon_det = 1'b1; xoff_det = 1'b1;
    @(negedge clk);
    xon_det = 1'b0; xoff_det = 1'b0;
    check("R8 set wins", isr, 8'hD0);

    // R7 masked extended source stays latched
    do_reset();
    ext_en = 1'b0;
    pulse_ev(5'b10000);
    read_isr();
    check("R7 masked", isr, 8'hC1);
    ext_en = 1'b1;
    @(negedge clk);
    check("R7 unmasked", isr, 8'hE0);

    // R9 disabled source kept and reported after enable
    do_reset();
    src_en = 6'h3B;
    pulse_ev(5'b00010);
    read_isr();
    check("R9 masked", isr, 8'hC1);
    src_en = 6'h3F;
    @(negedge clk);
    check("R9 enabled", isr, 8'hC2);

    // R2 prefix follows fifo_en alone
    fifo_en = 1'b0;
    @(negedge clk);
    check("R2 fifo off", isr, 8'h02);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule